// File: doc/BRIEF.md
# Four-Character Double-Buffered Word Loader

This block assembles a 16-bit data word that arrives as four consecutive 4-bit characters over a byte-serial instrument bus. The block acts only while the device is addressed as a listener and the bus is in data mode, which means ATN is high. On every leading edge of the accepted-byte signal it emits a capture strobe of fixed width. In the same cycle it writes the low nibble of the bus into the first-stage latch that the character sequencer currently points at.

The first character of a word is the range character, and the three characters after it are magnitude characters. When the fourth character arrives, all four nibbles move together into a second-stage output register. At that moment a one-cycle word-valid pulse is issued. Between full words the output holds steady, so whatever consumes it never sees a half-updated value. A sequencer clear input handles unlisten and interface clear. It drops any partial word and re-arms the sequencer for a new range character.

Top module: `nibble_word_loader`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `word_o` is 0, `word_valid_o` is 0 and `strobe_o` is 0.
- R2: A qualified leading edge of `accept_i` drives `strobe_o` high for exactly `STROBE_CYCLES` consecutive cycles. The pulse starts on the clock edge that first samples `accept_i` high.
- R3: When `listen_i` is low or `atn_i` is low, an edge on `accept_i` produces no strobe and stores no character.
- R4: Only the low-to-high transition of `accept_i` counts. Holding it high for many cycles stores exactly one character.
- R5: A character is `data_i[3:0]`, with bit 3 as the MSB. In the finished word, the first (range) character sits in bits 15:12, the second in 11:8, the third in 7:4 and the fourth in 3:0.
- R6: `word_o` changes only when a fourth character completes a word. After one, two or three characters it keeps its previous value.
- R7: `word_valid_o` is high for exactly one cycle. That cycle is the one in which the new word first appears on `word_o`.
- R8: `seq_clear_i` discards a partial word without changing `word_o`. The next stored character becomes the range character.
- R9: After a complete word the sequencer returns to the first position, so the next four characters form the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| listen_i | input | 1 | Device is addressed as listener |
| atn_i | input | 1 | Bus attention line; high means data mode |
| accept_i | input | 1 | Accepted-byte signal from the handshake logic |
| data_i | input | 4 | Bus data lines 4 (bit 3) down to 1 (bit 0) |
| seq_clear_i | input | 1 | Unlisten / interface clear: reset the sequencer |
| word_o | output | 16 | Second-stage held word {range, mag1, mag2, mag3} |
| word_valid_o | output | 1 | One-cycle pulse when `word_o` is updated |
| strobe_o | output | 1 | Fixed-width capture strobe |

## Verification
The capture path is driven in several ways. Edges arrive with listening off and with ATN low; the characters sent in those cases carry values that would corrupt the next word if they were wrongly stored. Another pattern holds the accept signal high for many cycles, which separates edge detection from level detection. Partial words followed by a clear, and two words sent back to back, show whether the sequencer position is kept, wrapped or discarded correctly. Distinct nibble values in every slot expose any ordering or bit-position error in the assembled word.

// File: rtl/nwl_pkg.sv
package nwl_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nibble_t;
endpackage

// File: rtl/nwl_strobe_gen.sv
module nwl_strobe_gen #(
  parameter int STROBE_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic enable_i,
  input  logic accept_i,
  output logic capture_o,
  output logic strobe_o
);
  localparam int CNT_W = (STROBE_CYCLES < 2) ? 1 : $clog2(STROBE_CYCLES);

  logic             accept_q;
  logic [CNT_W-1:0] remain_q;

  assign capture_o = enable_i & accept_i & ~accept_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_q <= 1'b0;
    end else begin
      accept_q <= accept_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      strobe_o <= 1'b0;
      remain_q <= '0;
    end else if (capture_o) begin
      strobe_o <= 1'b1;
      remain_q <= CNT_W'(STROBE_CYCLES - 1);
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end else begin
      strobe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nwl_sequencer.sv
module nwl_sequencer #(
  parameter int CHARS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CHARS-1:0] slot_oh_o,
  output logic             last_o
);
  localparam int POS_W = (CHARS < 2) ? 1 : $clog2(CHARS);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pos_q <= '0;
    end else if (step_i) begin
      if (pos_q == POS_W'(CHARS - 1)) pos_q <= '0;
      else                            pos_q <= pos_q + 1'b1;
    end
  end

  for (genvar i = 0; i < CHARS; i++) begin : g_slot
    assign slot_oh_o[i] = (pos_q == POS_W'(i));
  end

  assign last_o = slot_oh_o[CHARS-1];
endmodule

// File: rtl/nwl_word_store.sv
module nwl_word_store
  import nwl_pkg::*;
#(
  parameter int CHARS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_i,
  input  logic [CHARS-1:0]       slot_oh_i,
  input  logic                   last_i,
  input  nibble_t                data_i,
  output logic [CHARS*NIB_W-1:0] word_o,
  output logic                   valid_o
);
  localparam int WORD_W = CHARS * NIB_W;

  nibble_t             stage1 [CHARS-1];
  logic [WORD_W-1:0]   next_word;

  for (genvar i = 0; i < CHARS - 1; i++) begin : g_stage1
    always_ff @(posedge clk) begin
      if (rst)                       stage1[i] <= '0;
      else if (wr_i && slot_oh_i[i]) stage1[i] <= data_i;
    end
    assign next_word[(CHARS-1-i)*NIB_W +: NIB_W] = stage1[i];
  end
  assign next_word[NIB_W-1:0] = data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= wr_i & last_i;
      if (wr_i && last_i) word_o <= next_word;
    end
  end
endmodule

// File: rtl/nibble_word_loader.sv
module nibble_word_loader
  import nwl_pkg::*;
#(
  parameter int CHARS         = 4,
  parameter int STROBE_CYCLES = 200
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   listen_i,
  input  logic                   atn_i,
  input  logic                   accept_i,
  input  logic [NIB_W-1:0]       data_i,
  input  logic                   seq_clear_i,
  output logic [CHARS*NIB_W-1:0] word_o,
  output logic                   word_valid_o,
  output logic                   strobe_o
);
  logic             capture;
  logic             wr;
  logic [CHARS-1:0] slot_oh;
  logic             last;

  nwl_strobe_gen #(.STROBE_CYCLES(STROBE_CYCLES)) i_strobe (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (seq_clear_i),
    .enable_i  (listen_i & atn_i),
    .accept_i  (accept_i),
    .capture_o (capture),
    .strobe_o  (strobe_o)
  );

  assign wr = capture & ~seq_clear_i;

  nwl_sequencer #(.CHARS(CHARS)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (seq_clear_i),
    .step_i    (wr),
    .slot_oh_o (slot_oh),
    .last_o    (last)
  );

  nwl_word_store #(.CHARS(CHARS)) i_store (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (wr),
    .slot_oh_i (slot_oh),
    .last_i    (last),
    .data_i    (data_i),
    .word_o    (word_o),
    .valid_o   (word_valid_o)
  );
endmodule

// File: rtl/nwl_checker.sv
module nwl_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              listen_i,
  input logic              atn_i,
  input logic              seq_clear_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              strobe_o
);
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);

  assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!word_valid_o && !$past(rst)) |-> $stable(word_o));

  assert_strobe_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(strobe_o)) |-> $past(listen_i && atn_i));

  assert_valid_with_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> strobe_o);

  assert_clear_no_word_R8: assert property (@(posedge clk) disable iff (rst)
    $past(seq_clear_i) |-> !word_valid_o);
endmodule

bind nibble_word_loader nwl_checker #(.WORD_W(CHARS*nwl_pkg::NIB_W)) i_nwl_checker (
  .clk          (clk),
  .rst          (rst),
  .listen_i     (listen_i),
  .atn_i        (atn_i),
  .seq_clear_i  (seq_clear_i),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .strobe_o     (strobe_o)
);

// File: tb/test_nibble_word_loader.sv
module test_nibble_word_loader;
  localparam int CLK_PERIOD = 10;
  localparam int SC         = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        listen_i = 1'b0;
  logic        atn_i = 1'b0;
  logic        accept_i = 1'b0;
  logic [3:0]  data_i = '0;
  logic        seq_clear_i = 1'b0;
  logic [15:0] word_o;
  logic        word_valid_o;
  logic        strobe_o;

  int n_checks = 0;
  int n_fail   = 0;
  int n_valid  = 0;
  logic done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_word_loader #(.CHARS(4), .STROBE_CYCLES(SC)) i_nibble_word_loader (
    .clk(clk), .rst(rst), .listen_i(listen_i), .atn_i(atn_i),
    .accept_i(accept_i), .data_i(data_i), .seq_clear_i(seq_clear_i),
    .word_o(word_o), .word_valid_o(word_valid_o), .strobe_o(strobe_o)
  );

  always @(negedge clk) if (!rst && word_valid_o) n_valid++;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one accepted byte: raise accept at a falling edge, hold it for `hold` cycles.
  task automatic send_char(input logic [3:0] n, input int hold);
    data_i   = n;
    accept_i = 1'b1;
    repeat (hold) @(negedge clk);
    accept_i = 1'b0;
    repeat (SC + 1) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 3; i >= 0; i--) send_char(w[i*4 +: 4], 1);
  endtask

  task automatic t_reset;
    check("R1 word", word_o, 16'h0);
    check("R1 valid", {15'b0, word_valid_o}, 16'h0);
    check("R1 strobe", {15'b0, strobe_o}, 16'h0);
  endtask

  task automatic t_strobe_width;
    int cnt = 0;
    listen_i = 1'b1; atn_i = 1'b1;
    data_i = 4'h9; accept_i = 1'b1;
    for (int i = 0; i < 3 * SC; i++) begin
      @(negedge clk);
      accept_i = 1'b0;
      if (strobe_o) cnt++;
    end
    check("R2 strobe width", 16'(cnt), 16'(SC));
    seq_clear_i = 1'b1; @(negedge clk); seq_clear_i = 1'b0;
    check("R8 clear keeps word", word_o, 16'h0);
  endtask

  task automatic t_gating;
    int v0 = n_valid;
    listen_i = 1'b0; atn_i = 1'b1;
    send_char(4'hF, 1);
    check("R3 no strobe not listening", {15'b0, strobe_o}, 16'h0);
    listen_i = 1'b1; atn_i = 1'b0;
    send_char(4'hE, 1);
    check("R3 no strobe in command mode", {15'b0, strobe_o}, 16'h0);
    atn_i = 1'b1;
    send_word(16'h1234);
    check("R3 gated chars not stored", word_o, 16'h1234);
    check("R5 nibble order", word_o, 16'h1234);
    check("R7 one valid per word", 16'(n_valid - v0), 16'd1);
  endtask

  task automatic t_level_hold;
    send_char(4'hA, 1);
    send_char(4'hB, 12);
    send_char(4'hC, 1);
    send_char(4'hD, 1);
    check("R4 held accept stores once", word_o, 16'hABCD);
  endtask

  task automatic t_partial_clear;
    int v0 = n_valid;
    send_char(4'h5, 1); send_char(4'h6, 1); send_char(4'h7, 1);
    check("R6 word held after three chars", word_o, 16'hABCD);
    check("R6 no valid on partial", 16'(n_valid - v0), 16'd0);
    seq_clear_i = 1'b1; @(negedge clk); seq_clear_i = 1'b0;
    check("R8 clear keeps word", word_o, 16'hABCD);
    send_word(16'h8E21);
    check("R8 restart at range", word_o, 16'h8E21);
  endtask

  task automatic t_two_words;
    int v0 = n_valid;
    send_char(4'h3, 1); send_char(4'hC, 1); send_char(4'h0, 1);
    data_i = 4'hF; accept_i = 1'b1;
    @(negedge clk);
    accept_i = 1'b0;
    check("R7 valid with new word", {15'b0, word_valid_o}, 16'h1);
    check("R7 word visible with valid", word_o, 16'h3C0F);
    @(negedge clk);
    check("R7 valid one cycle", {15'b0, word_valid_o}, 16'h0);
    repeat (SC) @(negedge clk);
    send_word(16'h7A5B);
    check("R9 second word after wrap", word_o, 16'h7A5B);
    check("R9 two valid pulses", 16'(n_valid - v0), 16'd2);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_strobe_width;
    t_gating;
    t_level_hold;
    t_partial_clear;
    t_two_words;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule